// File: doc/BRIEF.md
# RS-485 Driver Direction Controller

This block drives the transmit-enable line of an RS-485 transceiver for one UART channel. When the transmitter has data waiting, the block turns the bus driver on. One bit time later it lets the transmitter start shifting, so the line has a settled setup interval. After the last stop bit of the last queued character, the block releases the driver. It can release at once, or hold the driver on for a programmable 1 to 15 further bit times so the final bits reach distant nodes on a long cable.

In half-duplex operation the block also tells the receive path to discard incoming data for as long as the driver is on, including the hold-off period. A polarity input selects whether the driver-enable pin is active high or active low. The UART shifter and the baud-rate generator sit outside this block: it sees only their strobes and a one-cycle bit-time tick.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: During and right after synchronous reset the controller is idle. `de_pin` sits at its released level, which equals `de_invert`. `tx_go` and `rx_ignore` are 0.
- R2: When idle and `tx_pending` is 1, the driver turns on in the cycle after that edge. `tx_go` stays 0 at that point.
- R3: `tx_go` rises only after the first `bit_tick` seen with the driver on, in the cycle after that tick. `tx_go` is never 1 while the driver is off.
- R4: With `turn_delay` = 0, a `stop_done` pulse while `tx_pending` is 0 releases the driver and drops `tx_go` in the very next cycle.
- R5: With `turn_delay` = N (1 to 15), a `stop_done` pulse while `tx_pending` is 0 keeps the driver on with `tx_go` at 0. The driver is released in the cycle after the Nth following `bit_tick`.
- R6: A `stop_done` pulse while `tx_pending` is still 1 leaves `tx_go` at 1 and the driver on.
- R7: If `tx_pending` or `char_start` goes to 1 during the hold-off countdown, the countdown is abandoned. `tx_go` returns to 1 in the next cycle and the driver stays on with no gap.
- R8: The driver is on when `de_pin` differs from `de_invert`. With `de_invert` = 1 the pin is low while driving and high while released.
- R9: With `hdx_en` = 1, `rx_ignore` is 1 in every cycle the driver is on, hold-off included. With `hdx_en` = 0, `rx_ignore` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pending | input | 1 | Transmit data is waiting to be sent |
| char_start | input | 1 | One-cycle strobe: transmitter began a character |
| stop_done | input | 1 | One-cycle strobe: last stop bit of a character finished |
| bit_tick | input | 1 | One-cycle strobe at each bit-time boundary |
| turn_delay | input | 4 | Hold-off after the final stop bit, in bit times (0 = none) |
| de_invert | input | 1 | 1 makes the driver-enable pin active low |
| hdx_en | input | 1 | Half-duplex: blank the receiver while the driver is on |
| de_pin | output | 1 | Transceiver driver-enable, polarity applied |
| tx_go | output | 1 | Permission for the transmitter to shift characters |
| rx_ignore | output | 1 | Receive path must drop incoming data |

## Verification
If the controller takes a wrong state, the ports show it within one clock. Releasing too early cuts `de_pin` back to its idle level while `tx_go` or the hold-off should still apply. A stuck countdown keeps the driver on past the Nth tick, which shows in the cycle after that tick. A missed cancel shows as a one-cycle gap in `de_pin` or a missing `tx_go`. A wrong blanking state shows at once as `rx_ignore` out of step with the driver level.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_SETUP = 2'd1,
    DIR_SEND  = 2'd2,
    DIR_HOLD  = 2'd3
  } dir_state_t;
endpackage

// File: rtl/rs485_hold_timer.sv
// Counts bit ticks during the post-transmit hold-off window.
module rs485_hold_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [DLY_W-1:0] LAST = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)
      remain_q <= '0;
    else if (load)
      remain_q <= load_val;
    else if (tick && remain_q != '0)
      remain_q <= remain_q - LAST;
  end

  assign expire = tick && (remain_q == LAST);
endmodule

// File: rtl/rs485_dir_fsm.sv
// Sequencing of driver setup, sending and hold-off.
module rs485_dir_fsm
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_pending,
  input  logic             char_start,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] turn_delay,
  input  logic             expire,
  output logic             load_hold,
  output dir_state_t       state_q,
  output dir_state_t       state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DIR_IDLE:  if (tx_pending) state_d = DIR_SETUP;
      DIR_SETUP: begin
        if (bit_tick)         state_d = DIR_SEND;
        else if (!tx_pending) state_d = DIR_IDLE;
      end
      DIR_SEND: begin
        if (stop_done && !tx_pending)
          state_d = (turn_delay == '0) ? DIR_IDLE : DIR_HOLD;
      end
      DIR_HOLD: begin
        if (tx_pending || char_start) state_d = DIR_SEND;
        else if (expire)              state_d = DIR_IDLE;
      end
      default: state_d = DIR_IDLE;
    endcase
  end

  assign load_hold = (state_q == DIR_SEND) && (state_d == DIR_HOLD);

  always_ff @(posedge clk) begin
    if (rst) state_q <= DIR_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/rs485_pin_stage.sv
// Output registers, loaded from the next state.
module rs485_pin_stage
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dir_state_t state_d,
  input  logic       de_invert,
  input  logic       hdx_en,
  output logic       de_pin,
  output logic       tx_go,
  output logic       rx_ignore
);
  logic drive_d;
  assign drive_d = (state_d != DIR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      de_pin    <= de_invert;
      tx_go     <= 1'b0;
      rx_ignore <= 1'b0;
    end else begin
      de_pin    <= drive_d ^ de_invert;
      tx_go     <= (state_d == DIR_SEND);
      rx_ignore <= drive_d && hdx_en;
    end
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_pending,
  input  logic             char_start,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] turn_delay,
  input  logic             de_invert,
  input  logic             hdx_en,
  output logic             de_pin,
  output logic             tx_go,
  output logic             rx_ignore
);
  dir_state_t state_q, state_d;
  logic       load_hold, expire;

  rs485_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .load(load_hold), .load_val(turn_delay),
    .tick(bit_tick), .expire(expire)
  );

  rs485_dir_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst(rst), .tx_pending(tx_pending), .char_start(char_start),
    .stop_done(stop_done), .bit_tick(bit_tick), .turn_delay(turn_delay),
    .expire(expire), .load_hold(load_hold), .state_q(state_q), .state_d(state_d)
  );

  rs485_pin_stage u_pins (
    .clk(clk), .rst(rst), .state_d(state_d), .de_invert(de_invert),
    .hdx_en(hdx_en), .de_pin(de_pin), .tx_go(tx_go), .rx_ignore(rx_ignore)
  );

  logic de_on;
  assign de_on = de_pin ^ de_invert;

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_IDLE && tx_pending) |=> (de_on && !tx_go));

  // R3
  go_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> de_on);

  // R4
  zero_delay_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_SEND && stop_done && !tx_pending && turn_delay == '0)
      |=> (!de_on && !tx_go));

  // R5
  hold_keeps_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_HOLD && !tx_pending && !char_start && !expire)
      |=> (de_on && !tx_go));

  // R7
  hold_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_HOLD && tx_pending) |=> (tx_go && de_on));

  // R9
  rx_blank_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ignore |-> de_on);
endmodule

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_pending = 0, char_start = 0, stop_done = 0, bit_tick = 0;
  logic [3:0] turn_delay = 0;
  logic de_invert = 0, hdx_en = 1;
  logic de_pin, tx_go, rx_ignore;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_dir_ctrl dut (
    .clk(clk), .rst(rst), .tx_pending(tx_pending), .char_start(char_start),
    .stop_done(stop_done), .bit_tick(bit_tick), .turn_delay(turn_delay),
    .de_invert(de_invert), .hdx_en(hdx_en),
    .de_pin(de_pin), .tx_go(tx_go), .rx_ignore(rx_ignore)
  );

  // One clock: drive strobes, advance to the next falling edge.
  task automatic step(input logic tk, input logic cs, input logic sd);
    bit_tick = tk; char_start = cs; stop_done = sd;
    @(negedge clk);
    bit_tick = 0; char_start = 0; stop_done = 0;
  endtask

  task automatic expect_out(input string req, input logic drv, input logic go, input logic ign);
    logic [2:0] exp_v, act_v;
    exp_v = {drv ^ de_invert, go, ign};
    act_v = {de_pin, tx_go, rx_ignore};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: {de_pin,tx_go,rx_ignore} actual=%b expected=%b", req, act_v, exp_v);
    end
  endtask

  task automatic do_reset();
    rst = 1; tx_pending = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  // Bring the driver on and reach the sending state.
  task automatic start_send();
    tx_pending = 1;
    step(0, 0, 0);
    expect_out("R2", 1, 0, hdx_en);
    step(0, 0, 0);
    expect_out("R3", 1, 0, hdx_en);
    step(1, 0, 0);
    expect_out("R3", 1, 1, hdx_en);
    step(0, 1, 0);
  endtask

  task automatic t_reset();
    de_invert = 0; do_reset();
    expect_out("R1", 0, 0, 0);
    de_invert = 1; do_reset();
    expect_out("R1", 0, 0, 0);
    de_invert = 0; do_reset();
  endtask

  task automatic t_zero_delay();
    turn_delay = 0; hdx_en = 1;
    start_send();
    tx_pending = 0;
    step(0, 0, 1);
    expect_out("R4", 0, 0, 0);
  endtask

  task automatic t_delay(input int n);
    turn_delay = 4'(n); hdx_en = 1;
    start_send();
    tx_pending = 0;
    step(0, 0, 1);
    expect_out("R5", 1, 0, 1);
    for (int i = 1; i <= n; i++) begin
      step(0, 0, 0);
      expect_out("R5", 1, 0, 1);
      step(1, 0, 0);
      if (i < n) expect_out("R5", 1, 0, 1);
      else       expect_out("R5", 0, 0, 0);
    end
  endtask

  task automatic t_back_to_back();
    turn_delay = 3;
    start_send();
    step(0, 0, 1);
    expect_out("R6", 1, 1, hdx_en);
    tx_pending = 0;
    step(0, 0, 1);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    expect_out("R6", 0, 0, 0);
  endtask

  task automatic t_cancel();
    turn_delay = 5;
    start_send();
    tx_pending = 0;
    step(0, 0, 1);
    step(1, 0, 0);
    expect_out("R7", 1, 0, hdx_en);
    step(1, 0, 0);
    tx_pending = 1;
    step(0, 0, 0);
    expect_out("R7", 1, 1, hdx_en);
    tx_pending = 0;
    step(0, 0, 1);
    step(1, 0, 0);
    step(0, 1, 0);
    expect_out("R7", 1, 1, hdx_en);
    step(0, 0, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    expect_out("R7", 0, 0, 0);
  endtask

  task automatic t_polarity();
    de_invert = 1; do_reset();
    expect_out("R8", 0, 0, 0);
    turn_delay = 0;
    start_send();
    checks++;
    if (de_pin !== 1'b0) begin
      fails++;
      $display("FAIL R8: de_pin actual=%b expected=0", de_pin);
    end
    tx_pending = 0;
    step(0, 0, 1);
    expect_out("R8", 0, 0, 0);
    de_invert = 0; do_reset();
  endtask

  task automatic t_hdx_off();
    hdx_en = 0; turn_delay = 2;
    start_send();
    expect_out("R9", 1, 1, 0);
    tx_pending = 0;
    step(0, 0, 1);
    expect_out("R9", 1, 0, 0);
    step(1, 0, 0); step(1, 0, 0);
    expect_out("R9", 0, 0, 0);
    hdx_en = 1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zero_delay();
    t_delay(1);
    t_delay(4);
    t_delay(15);
    t_back_to_back();
    t_cancel();
    t_polarity();
    t_hdx_off();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule